// File: doc/BRIEF.md
# Successive-Approximation Converter Sequencer

This block is the digital controller of an 8-bit analog-to-digital converter that serves four multiplexed inputs. Software writes a control byte holding an enable, a start/busy bit, a completion flag, a channel number, a spare bit and a conversion-clock choice. Setting the start bit while the enable is on begins an eight-step successive-approximation search. Each step lasts one conversion-clock period. The block presents a trial code to an external DAC and comparator, and it reads back a single comparator decision for each step.

When the last bit is resolved, the block stores the 8-bit result, clears the start bit in hardware and raises the completion flag. The flag stays set until software writes it low. The conversion clock is the system clock divided by 2, 8 or 32. A fourth setting takes its divisor from the oscillator mode input.

A separate 2-bit pin-usage field is decoded into per-pin analog enables and a flag that selects an external voltage reference.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset the control byte reads 0x00, the pin-usage field reads 00, all four pins are analog, the external reference flag is 0 and the trial code is 0x80.
- R2: A control write with the start bit (bit 2) set but the enable (bit 0) clear leaves bit 2 reading 0. No conversion runs, the flag stays 0 and the result is unchanged.
- R3: With the enable set, setting bit 2 runs a search from MSB to LSB. The trial code is 0x80 before the first step, and after the first step it is 0xC0 if the input is at least 128 and 0x40 otherwise. A comparator input of 1 means the input is at or above the trial code. The final result equals the input level, bit 2 returns to 0 and the flag (bit 1) becomes 1.
- R4: The clock field (bits 7:6) selects the divisor: 00 gives 2, 01 gives 8 and 10 gives 32. Bit 2 reads 0 exactly 8×divisor cycles after the write edge that set it.
- R5: Clock field 11 takes its divisor from osc_mode: 32 for 11 (high-frequency crystal), 8 for 10 (standard crystal), and 2 for 00 (RC) or 01 (low-frequency crystal).
- R6: Once set, the completion flag stays 1 until a control write puts a 0 in bit 1.
- R7: Bits 4:3 select the channel. Their value appears on chan_sel, and the conversion uses that channel's comparator decisions.
- R8: Bit 5 reads back what was written and has no effect on the conversion.
- R9: Pin-usage value 00 gives analog pins 1111 with reference 0. Value 01 gives 0111 with reference 1. Value 10 gives 0011 with reference 0. Value 11 gives 0000 with reference 0. The outputs follow one cycle after the write.
- R10: The result changes only when a conversion completes, and reset does not clear it.
- R11: Clearing the enable during a conversion aborts it. Bit 2 reads 0, the flag stays 0 and the result is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_we | input | 1 | Control byte write strobe |
| ctrl_wdata | input | 8 | Control byte write data |
| pmode_we | input | 1 | Pin-usage field write strobe |
| pmode_wdata | input | 2 | Pin-usage field write data |
| osc_mode | input | 2 | Oscillator mode: 00 RC, 01 low-freq crystal, 10 crystal, 11 high-freq crystal |
| cmp_hi | input | 1 | Comparator decision: input at or above trial code |
| ctrl_rdata | output | 8 | Control byte read value |
| pmode_rdata | output | 2 | Pin-usage field read value |
| result | output | 8 | Last conversion result |
| trial_code | output | 8 | Code driven to the external DAC |
| chan_sel | output | 2 | Multiplexer channel select |
| pin_analog | output | 4 | Per-pin analog enable |
| vref_ext | output | 1 | Use pin 3 as the reference |

## Verification
The assertions assume that the comparator decision is a function of the current trial code and the selected channel only, and that the oscillator mode and the clock field hold still while a conversion runs. The bench models the analog side as one fixed byte per channel and compares it against the trial code. It changes channel levels, osc_mode and clock settings only while bit 2 reads 0. The only control write made during a conversion is the deliberate abort.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    OSC_RC = 2'b00,
    OSC_LF = 2'b01,
    OSC_XT = 2'b10,
    OSC_HF = 2'b11
  } osc_mode_e;

  localparam int CTL_EN    = 0;
  localparam int CTL_FLAG  = 1;
  localparam int CTL_GO    = 2;
  localparam int CTL_CH_LO = 3;
  localparam int CTL_SPARE = 5;
  localparam int CTL_CK_LO = 6;

  function automatic int unsigned conv_div(input logic [1:0] sel,
                                           input logic [1:0] osc,
                                           input int unsigned d_fast,
                                           input int unsigned d_mid,
                                           input int unsigned d_slow);
    int unsigned d;
    case (sel)
      2'b00:   d = d_fast;
      2'b01:   d = d_mid;
      2'b10:   d = d_slow;
      default: begin
        if (osc == OSC_HF)      d = d_slow;
        else if (osc == OSC_XT) d = d_mid;
        else                    d = d_fast;
      end
    endcase
    return d;
  endfunction

endpackage

// File: rtl/adc_clk_div.sv
module adc_clk_div
  import adc_seq_pkg::*;
#(
  parameter int unsigned DIV_FAST = 2,
  parameter int unsigned DIV_MID  = 8,
  parameter int unsigned DIV_SLOW = 32
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic [1:0] ck_sel,
  input  logic [1:0] osc,
  output logic       tick
);
  localparam int CNT_W = $clog2(DIV_SLOW);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] lim;

  always_comb begin
    lim  = CNT_W'(conv_div(ck_sel, osc, DIV_FAST, DIV_MID, DIV_SLOW) - 1);
    tick = run && (cnt_q == lim);
  end

  always_ff @(posedge clk) begin
    if (rst || !run)  cnt_q <= '0;
    else if (tick)    cnt_q <= '0;
    else              cnt_q <= cnt_q + CNT_W'(1);
  end

  // R4: every divisor is at least 2, so step pulses never come back to back
  a_r4_no_adjacent_ticks: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);

endmodule

// File: rtl/adc_sar_engine.sv
module adc_sar_engine #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              active,
  input  logic              step,
  input  logic              cmp_hi,
  output logic [DATA_W-1:0] trial,
  output logic              done,
  output logic [DATA_W-1:0] result
);
  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [DATA_W-1:0] SEED = DATA_W'(1) << (DATA_W - 1);

  logic [IDX_W-1:0]  idx_q;
  logic [DATA_W-1:0] trial_q, trial_d, res_q;

  always_comb begin
    trial_d = trial_q;
    trial_d[idx_q] = cmp_hi;
    if (idx_q != '0) trial_d[idx_q - IDX_W'(1)] = 1'b1;
    done = active && step && (idx_q == '0);
  end

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      trial_q <= SEED;
      idx_q   <= IDX_W'(DATA_W - 1);
    end else if (step) begin
      trial_q <= trial_d;
      if (idx_q != '0) idx_q <= idx_q - IDX_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (done) res_q <= trial_d;
  end

  assign trial  = trial_q;
  assign result = res_q;

  // R3: while searching, the bit under test is always probed high
  a_r3_probe_bit_high: assert property (@(posedge clk) disable iff (rst)
    (active && !step) |-> trial_q[idx_q]);

  // R10: result moves only on a completion
  a_r10_result_hold: assert property (@(posedge clk) disable iff (rst)
    !done |=> $stable(res_q));

endmodule

// File: rtl/adc_pin_map.sv
module adc_pin_map #(
  parameter int N_PIN = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [1:0]       wdata,
  output logic [1:0]       mode,
  output logic [N_PIN-1:0] analog,
  output logic             vref_ext
);
  localparam int CNT_W = $clog2(N_PIN + 1);

  logic [CNT_W-1:0] n_analog;
  logic [N_PIN-1:0] analog_d;
  logic [1:0]       mode_q;
  logic [N_PIN-1:0] analog_q;
  logic             vref_q;

  always_comb begin
    case (wdata)
      2'b00:   n_analog = CNT_W'(N_PIN);
      2'b01:   n_analog = CNT_W'(N_PIN - 1);
      2'b10:   n_analog = CNT_W'(N_PIN / 2);
      default: n_analog = '0;
    endcase
  end

  for (genvar i = 0; i < N_PIN; i++) begin : g_pin
    assign analog_d[i] = (CNT_W'(i) < n_analog);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= 2'b00;
      analog_q <= '1;
      vref_q   <= 1'b0;
    end else if (we) begin
      mode_q   <= wdata;
      analog_q <= analog_d;
      vref_q   <= (wdata == 2'b01);
    end
  end

  assign mode     = mode_q;
  assign analog   = analog_q;
  assign vref_ext = vref_q;

  // R9: the reference pin is never also a conversion input
  a_r9_vref_pin_digital: assert property (@(posedge clk) disable iff (rst)
    vref_q |-> !analog_q[N_PIN-1]);

  // R9: the decode never leaves exactly one analog pin
  a_r9_no_single_analog: assert property (@(posedge clk) disable iff (rst)
    $countones(analog_q) != 1);

endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int          DATA_W   = 8,
  parameter int          N_PIN    = 4,
  parameter int unsigned DIV_FAST = 2,
  parameter int unsigned DIV_MID  = 8,
  parameter int unsigned DIV_SLOW = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_we,
  input  logic [7:0]        ctrl_wdata,
  input  logic              pmode_we,
  input  logic [1:0]        pmode_wdata,
  input  logic [1:0]        osc_mode,
  input  logic              cmp_hi,
  output logic [7:0]        ctrl_rdata,
  output logic [1:0]        pmode_rdata,
  output logic [DATA_W-1:0] result,
  output logic [DATA_W-1:0] trial_code,
  output logic [1:0]        chan_sel,
  output logic [N_PIN-1:0]  pin_analog,
  output logic              vref_ext
);
  logic [7:0] ctrl_q, ctrl_d;
  logic       step, conv_done;

  always_comb begin
    ctrl_d = ctrl_q;
    if (ctrl_we) ctrl_d = ctrl_wdata;
    if (!ctrl_d[CTL_EN]) ctrl_d[CTL_GO] = 1'b0;
    if (conv_done) begin
      ctrl_d[CTL_FLAG] = 1'b1;
      ctrl_d[CTL_GO]   = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) ctrl_q <= 8'h00;
    else     ctrl_q <= ctrl_d;
  end

  adc_clk_div #(
    .DIV_FAST(DIV_FAST), .DIV_MID(DIV_MID), .DIV_SLOW(DIV_SLOW)
  ) u_div (
    .clk    (clk),
    .rst    (rst),
    .run    (ctrl_q[CTL_GO]),
    .ck_sel (ctrl_q[CTL_CK_LO +: 2]),
    .osc    (osc_mode),
    .tick   (step)
  );

  adc_sar_engine #(.DATA_W(DATA_W)) u_sar (
    .clk    (clk),
    .rst    (rst),
    .active (ctrl_q[CTL_GO]),
    .step   (step),
    .cmp_hi (cmp_hi),
    .trial  (trial_code),
    .done   (conv_done),
    .result (result)
  );

  adc_pin_map #(.N_PIN(N_PIN)) u_pins (
    .clk      (clk),
    .rst      (rst),
    .we       (pmode_we),
    .wdata    (pmode_wdata),
    .mode     (pmode_rdata),
    .analog   (pin_analog),
    .vref_ext (vref_ext)
  );

  assign ctrl_rdata = ctrl_q;
  assign chan_sel   = ctrl_q[CTL_CH_LO +: 2];

  // R2: a running conversion always has the module enabled
  a_r2_go_needs_enable: assert property (@(posedge clk) disable iff (rst)
    ctrl_q[CTL_GO] |-> ctrl_q[CTL_EN]);

  // R3: completion raises the flag and drops the start bit
  a_r3_done_updates_ctrl: assert property (@(posedge clk) disable iff (rst)
    conv_done |=> (ctrl_q[CTL_FLAG] && !ctrl_q[CTL_GO]));

  // R6: without a write the flag cannot fall
  a_r6_flag_sticky: assert property (@(posedge clk) disable iff (rst)
    (ctrl_q[CTL_FLAG] && !ctrl_we) |=> ctrl_q[CTL_FLAG]);

endmodule

// File: tb/adc_seq_ctrl_tb.sv
module adc_seq_ctrl_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ctrl_we = 1'b0;
  logic [7:0] ctrl_wdata = 8'h00;
  logic       pmode_we = 1'b0;
  logic [1:0] pmode_wdata = 2'b00;
  logic [1:0] osc_mode = 2'b00;
  logic       cmp_hi;
  logic [7:0] ctrl_rdata, result, trial_code;
  logic [1:0] pmode_rdata, chan_sel;
  logic [3:0] pin_analog;
  logic       vref_ext;

  logic [7:0] ain [4];
  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  assign cmp_hi = (ain[chan_sel] >= trial_code);

  adc_seq_ctrl u_dut (
    .clk(clk), .rst(rst), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .pmode_we(pmode_we), .pmode_wdata(pmode_wdata), .osc_mode(osc_mode),
    .cmp_hi(cmp_hi), .ctrl_rdata(ctrl_rdata), .pmode_rdata(pmode_rdata),
    .result(result), .trial_code(trial_code), .chan_sel(chan_sel),
    .pin_analog(pin_analog), .vref_ext(vref_ext)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr_ctrl(input logic [7:0] v);
    @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = v;
    @(negedge clk); ctrl_we = 1'b0;
  endtask

  task automatic wr_pmode(input logic [1:0] v);
    @(negedge clk); pmode_we = 1'b1; pmode_wdata = v;
    @(negedge clk); pmode_we = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1 ctrl", ctrl_rdata, 8'h00);
    chk("R1 pmode", pmode_rdata, 2'b00);
    chk("R1 pins", pin_analog, 4'hF);
    chk("R1 vref", vref_ext, 0);
    chk("R1 trial", trial_code, 8'h80);
  endtask

  // R3 R4 R5 R7 R8: one full conversion with cycle count
  task automatic t_conv(input logic [1:0] sel, input logic [1:0] osc,
                        input logic [1:0] ch, input logic spare, input int d);
    int n = 0;
    logic [7:0] v = {sel, spare, ch, 3'b101};
    osc_mode = osc;
    wr_ctrl(v);
    chk("R7 chan_sel", chan_sel, ch);
    chk("R3 first trial", trial_code, 8'h80);
    while (ctrl_rdata[2] && n < 2000) begin
      @(negedge clk); n++;
      if (n == d)
        chk("R3 after first step", trial_code, (ain[ch] >= 8'd128) ? 8'hC0 : 8'h40);
    end
    chk((sel == 2'b11) ? "R5 length" : "R4 length", n, 8 * d);
    chk("R3 result", result, ain[ch]);
    chk("R3 R8 ctrl after done", ctrl_rdata, {sel, spare, ch, 3'b011});
  endtask

  task automatic t_flag_clear;
    logic [7:0] v = ctrl_rdata;
    idle(10);
    chk("R6 flag held", ctrl_rdata[1], 1);
    wr_ctrl(v & 8'hFD);
    chk("R6 flag cleared", ctrl_rdata, v & 8'hFD);
  endtask

  task automatic t_disabled_go;
    logic [7:0] r = result;
    wr_ctrl(8'h0C);
    chk("R2 go dropped", ctrl_rdata, 8'h08);
    idle(40);
    chk("R2 no flag", ctrl_rdata, 8'h08);
    chk("R2 result kept", result, r);
    chk("R2 trial idle", trial_code, 8'h80);
  endtask

  task automatic t_spare_rw;
    wr_ctrl(8'h20);
    chk("R8 spare readback", ctrl_rdata, 8'h20);
    wr_ctrl(8'h00);
    chk("R8 spare clear", ctrl_rdata, 8'h00);
  endtask

  task automatic t_abort;
    logic [7:0] r = result;
    osc_mode = 2'b00;
    wr_ctrl(8'h85);
    idle(20);
    chk("R11 still running", ctrl_rdata[2], 1);
    wr_ctrl(8'h84);
    chk("R11 go dropped", ctrl_rdata, 8'h80);
    idle(300);
    chk("R11 no flag", ctrl_rdata[1], 0);
    chk("R11 result kept", result, r);
  endtask

  task automatic t_pins;
    wr_pmode(2'b01);
    chk("R9 mode01 pins", pin_analog, 4'b0111);
    chk("R9 mode01 vref", vref_ext, 1);
    wr_pmode(2'b10);
    chk("R9 mode10 pins", pin_analog, 4'b0011);
    chk("R9 mode10 vref", vref_ext, 0);
    wr_pmode(2'b11);
    chk("R9 mode11 pins", pin_analog, 4'b0000);
    chk("R9 mode11 read", pmode_rdata, 2'b11);
    wr_pmode(2'b00);
    chk("R9 mode00 pins", pin_analog, 4'b1111);
    chk("R9 mode00 vref", vref_ext, 0);
  endtask

  task automatic t_reset_keeps_result;
    logic [7:0] r = result;
    wr_pmode(2'b11);
    @(negedge clk); rst = 1'b1;
    idle(2);
    rst = 1'b0;
    idle(1);
    chk("R10 result survives reset", result, r);
    chk("R1 ctrl after reset", ctrl_rdata, 8'h00);
    chk("R1 pins after reset", pin_analog, 4'hF);
  endtask

  initial begin
    ain[0] = 8'hA5; ain[1] = 8'h3C; ain[2] = 8'hFF; ain[3] = 8'h00;
    idle(3);
    rst = 1'b0;
    idle(1);
    t_reset();
    t_conv(2'b00, 2'b10, 2'd0, 1'b0, 2);
    t_flag_clear();
    t_conv(2'b01, 2'b11, 2'd1, 1'b1, 8);
    t_conv(2'b10, 2'b00, 2'd2, 1'b0, 32);
    t_conv(2'b11, 2'b11, 2'd3, 1'b0, 32);
    t_conv(2'b11, 2'b10, 2'd1, 1'b0, 8);
    t_conv(2'b11, 2'b01, 2'd0, 1'b1, 2);
    t_conv(2'b11, 2'b00, 2'd2, 1'b0, 2);
    ain[1] = 8'h80;
    t_conv(2'b00, 2'b00, 2'd1, 1'b0, 2);
    ain[3] = 8'h7F;
    t_conv(2'b01, 2'b00, 2'd3, 1'b0, 8);
    t_disabled_go();
    t_spare_rw();
    t_abort();
    t_pins();
    t_reset_keeps_result();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 100000; i++) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule